// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets a processor run transactions on a three-wire serial EEPROM that is organised in 16-bit words. The processor programs a data word and a command word through a small write port. It then writes a control word whose strobe bits start the transaction. The controller raises chip select and clocks out the low part of the command word, most significant bit first. Depending on the strobe, it then clocks 16 data bits out of the data buffer, or it samples 16 bits from the device into that buffer. A status byte shows whether the controller is idle, whether a read has finished, and whether protection is on.

Programming cycles (word write, write-all, erase, erase-all) end with a ready poll. The controller drops chip select for one tick and raises it again. It then stays busy until the device drives its data-out line high. A sticky protection bit blocks every programming strobe until reset. The parameter `ADDR_W` sets the address width of the part: 6 for 1 Kbit, 8 for 2/4 Kbit, 10 for 8/16 Kbit. The command frame is then `ADDR_W+3` bits long: a start bit, a 2-bit opcode and the address. The parameter `CLK_DIV` sets the serial clock half-period in system clocks.

Top module: `mw_host`

## Requirements
- R1: After reset, status reads idle (bit 1 = 1) with read-done (bit 0) and protection (bit 7) at 0, and chip select and serial clock are low.
- R2: A started transaction raises chip select and presents command bits `ADDR_W+2` down to 0, one per serial clock rising edge, most significant first.
- R3: A write strobe (control bit 5; port select 2) follows the command with the 16 data-buffer bits, most significant first. Chip select then drops, rises again, and the controller stays busy until data-out reads 1.
- R4: A read strobe (control bit 4) samples 16 bits from data-out on the rising edges after the command and stores them most significant first in the data buffer. It then sets status bit 0.
- R5: An erase-class strobe (control bit 6) sends only the command. It then polls for ready when the opcode (bits `ADDR_W+1:ADDR_W`) is 11, or when the opcode is 00 and the two top address bits are 10. Otherwise it returns to idle as soon as the frame ends.
- R6: Status bit 1 reads 0 from the cycle after a strobe is accepted until the transaction is over, and chip select is low whenever status bit 1 is 1.
- R7: Writing control bit 7 as 1 sets protection (status bit 7). Writing it as 0 later does not clear it; only reset does.
- R8: With protection set, including by the same control write, write and erase strobes start nothing and status stays idle. Read strobes still run.
- R9: Starting a transaction clears status bit 0.
- R10: The serial clock period is `2*CLK_DIV` system clocks, and the serial clock is low whenever chip select is low.
- R11: Writes to the data register (select 0), the command register (select 1) and control strobes are ignored while the controller is busy.
- R12: When several strobes are set in one control write, read wins over write, and write wins over erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 data, 1 command, 2 control |
| wr_data | input | 16 | Register write value |
| data_q | output | 16 | Data buffer contents |
| status | output | 8 | Bit 0 read done, bit 1 idle, bit 7 protection |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data / ready from the EEPROM |

## Verification
A control write can set protection and a programming strobe in the same cycle. The design must treat the strobe as already protected, so no transaction starts. The bench drives such a write right after a fresh reset. It then judges the result at the ports: status must stay idle, protection must read 1, and chip select must stay low for many serial periods. A second overlap comes from processor writes that land while a transaction is running. The bench writes the data register during a ready poll and requires the buffer to keep the word that was sent. It also issues a strobe during a read and requires exactly one read frame, after which the controller returns to idle.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DOUT, ST_DIN, ST_GAP, ST_POLL
  } mw_state_t;

  typedef enum logic [1:0] {
    K_RD, K_WR, K_ER
  } mw_kind_t;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // number of command bits on the wire: start + opcode + address
  function automatic int cmd_len(input int aw);
    return aw + 3;
  endfunction

  // erase-class commands that leave the device busy afterwards
  function automatic logic needs_poll(input logic [15:0] c, input int aw);
    logic [1:0] op;
    logic [1:0] sub;
    op  = c[aw+1 -: 2];
    sub = c[aw-1 -: 2];
    return (op == 2'b11) || (op == 2'b00 && sub == 2'b10);
  endfunction

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(DIV + 1);
  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        go_rd,
  input  logic        go_wr,
  input  logic        go_er,
  input  logic [15:0] cmd_in,
  input  logic [15:0] data_in,
  input  logic        ee_do,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  output logic        busy,
  output logic        rd_cap,
  output logic [15:0] rd_word
);
  localparam int CLEN = cmd_len(ADDR_W);

  mw_state_t   st;
  mw_kind_t    kind;
  logic        ph;
  logic        poll;
  logic [4:0]  cnt;
  logic [15:0] cmd_r;
  logic [15:0] osh;
  logic [15:0] ish;
  logic        last_fall;

  assign busy      = (st != ST_IDLE);
  assign last_fall = tick && ph && (cnt == 5'd0);
  assign rd_cap    = (st == ST_DIN) && last_fall;
  assign rd_word   = ish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      kind  <= K_RD;
      ph    <= 1'b0;
      poll  <= 1'b0;
      cnt   <= '0;
      cmd_r <= '0;
      osh   <= '0;
      ish   <= '0;
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      ee_di <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go_rd || go_wr || go_er) begin
            st    <= ST_CMD;
            kind  <= go_rd ? K_RD : (go_wr ? K_WR : K_ER);
            poll  <= needs_poll(cmd_in, ADDR_W);
            cmd_r <= cmd_in;
            osh   <= data_in;
            cnt   <= 5'(CLEN - 1);
            ph    <= 1'b0;
            ee_cs <= 1'b1;
            ee_sk <= 1'b0;
            ee_di <= cmd_in[CLEN-1];
          end
        end
        ST_CMD, ST_DOUT, ST_DIN: begin
          if (tick && !ph) begin
            ee_sk <= 1'b1;
            ph    <= 1'b1;
            if (st == ST_DIN) ish <= {ish[14:0], ee_do};
          end else if (tick) begin
            ee_sk <= 1'b0;
            ph    <= 1'b0;
            if (cnt != 5'd0) begin
              cnt <= cnt - 1'b1;
              if (st == ST_CMD)       ee_di <= cmd_r[cnt - 5'd1];
              else if (st == ST_DOUT) ee_di <= osh[cnt - 5'd1];
              else                    ee_di <= 1'b0;
            end else if (st == ST_CMD && kind == K_RD) begin
              st    <= ST_DIN;
              cnt   <= 5'd15;
              ee_di <= 1'b0;
            end else if (st == ST_CMD && kind == K_WR) begin
              st    <= ST_DOUT;
              cnt   <= 5'd15;
              ee_di <= osh[15];
            end else if (st == ST_DOUT || (st == ST_CMD && poll)) begin
              st    <= ST_GAP;
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
            end else begin
              st    <= ST_IDLE;
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            st    <= ST_POLL;
            ee_cs <= 1'b1;
          end
        end
        ST_POLL: begin
          if (tick && ee_do) begin
            st    <= ST_IDLE;
            ee_cs <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_host.sv
module mw_host
  import mw_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] data_q,
  output logic [7:0]  status,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  logic [15:0] cmd_q;
  logic        wp;
  logic        rdone;
  logic        busy;
  logic        tick;
  logic        rd_cap;
  logic [15:0] rd_word;
  logic        ctrl_wr;
  logic        wp_next;
  logic        go_rd, go_wr, go_er, go_any;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign wp_next = wp || (ctrl_wr && wr_data[7]);
  assign go_rd   = ctrl_wr && !busy && wr_data[4];
  assign go_wr   = ctrl_wr && !busy && !wr_data[4] && wr_data[5] && !wp_next;
  assign go_er   = ctrl_wr && !busy && !wr_data[4] && !wr_data[5] &&
                   wr_data[6] && !wp_next;
  assign go_any  = go_rd || go_wr || go_er;

  assign status  = {wp, 5'b0, !busy, rdone};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
      wp     <= 1'b0;
      rdone  <= 1'b0;
    end else begin
      if (rd_cap)
        data_q <= rd_word;
      else if (wr_en && wr_sel == SEL_DATA && !busy)
        data_q <= wr_data;
      if (wr_en && wr_sel == SEL_CMD && !busy)
        cmd_q <= wr_data;
      if (ctrl_wr && wr_data[7])
        wp <= 1'b1;
      if (go_any)      rdone <= 1'b0;
      else if (rd_cap) rdone <= 1'b1;
    end
  end

  mw_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (busy),
    .tick (tick)
  );

  mw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .go_rd  (go_rd),
    .go_wr  (go_wr),
    .go_er  (go_er),
    .cmd_in (cmd_q),
    .data_in(data_q),
    .ee_do  (ee_do),
    .ee_cs  (ee_cs),
    .ee_sk  (ee_sk),
    .ee_di  (ee_di),
    .busy   (busy),
    .rd_cap (rd_cap),
    .rd_word(rd_word)
  );
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [15:0] wr_data,
  input logic [15:0] data_q,
  input logic [7:0]  status,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        go_any,
  input logic        rd_cap,
  input logic [15:0] rd_word
);
  // R7: protection never falls once raised
  a_r7_wp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |=> status[7]);

  // R10: no serial clock outside a selected frame
  a_r10_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  // R6: idle means deselected
  a_r6_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> !ee_cs);

  // R6: accepted start makes status busy next cycle
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |=> !status[1]);

  // R8: protected programming strobes leave the controller idle
  a_r8_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && status[7] && status[1] && !wr_data[4])
      |=> status[1]);

  // R9: start clears read-done
  a_r9_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |=> !status[0]);

  // R4: capture lands in the buffer and flags completion
  a_r4_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> (status[0] && data_q == $past(rd_word)));

  // R11: buffer holds during a transaction except at capture
  a_r11_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[1] && !rd_cap) |=> $stable(data_q));
endmodule

bind mw_host mw_host_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .data_q (data_q),
  .status (status),
  .ee_cs  (ee_cs),
  .ee_sk  (ee_sk),
  .go_any (go_any),
  .rd_cap (rd_cap),
  .rd_word(rd_word)
);

// File: tb/test_mw_host.sv
module test_mw_host;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W  = 6;
  localparam int CLK_DIV = 4;
  localparam int CLEN    = ADDR_W + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] data_q;
  logic [7:0]  status;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mw_host #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) i_mw_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .data_q(data_q), .status(status),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // ---------------- device model ----------------
  logic        model_rd = 1'b0;
  logic        dev_ready = 1'b1;
  logic [15:0] rdpat = 16'h0;
  logic        rd_bit = 1'b0;
  int          dev_cnt = 0;
  logic [63:0] frame = '0;
  logic [63:0] snap_frame = '0;
  int          snap_n = 0;
  int          last_rise = 0;
  int          sk_period = 0;

  assign ee_do = model_rd ? rd_bit : dev_ready;

  always @(posedge ee_cs) begin
    dev_cnt = 0;
    frame   = '0;
  end
  always @(posedge ee_sk) begin
    if (ee_cs) begin
      frame     = {frame[62:0], ee_di};
      dev_cnt   = dev_cnt + 1;
      sk_period = int'($time) - last_rise;
      last_rise = int'($time);
    end
  end
  always @(negedge ee_sk) begin
    if (model_rd && dev_cnt >= CLEN && dev_cnt < CLEN + 16)
      rd_bit = rdpat[15 - (dev_cnt - CLEN)];
  end
  always @(negedge ee_cs) begin
    if (dev_cnt != 0) begin
      snap_frame = frame;
      snap_n     = dev_cnt;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (status[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    chk("R1 status", 32'(status), 32'h02);
    chk("R1 cs", 32'(ee_cs), 0);
    chk("R1 sk", 32'(ee_sk), 0);
  endtask

  task automatic t_write();
    dev_ready = 1'b0;
    cpu_wr(2'd0, 16'hA5C3);
    cpu_wr(2'd1, 16'h016A);
    cpu_wr(2'd2, 16'h0020);
    chk("R6 busy after write strobe", 32'(status[1]), 0);
    wait_clk(260);
    chk("R2/R3 write bit count", 32'(snap_n), CLEN + 16);
    chk("R2/R3 write frame", 32'(snap_frame[24:0]), 32'({9'h16A, 16'hA5C3}));
    chk("R3 busy while polling", 32'(status[1]), 0);
    chk("R3 cs high while polling", 32'(ee_cs), 1);
    cpu_wr(2'd0, 16'h1111);
    chk("R11 data write ignored while busy", 32'(data_q), 32'hA5C3);
    dev_ready = 1'b1;
    wait_idle(50);
    chk("R3 idle after ready", 32'(status[1]), 1);
    chk("R6 cs low when idle", 32'(ee_cs), 0);
  endtask

  task automatic t_read(input logic [15:0] pat, input logic [15:0] ctrl, input string req);
    rdpat = pat; model_rd = 1'b1;
    cpu_wr(2'd1, 16'h0195);
    cpu_wr(2'd2, ctrl);
    chk({req, " busy"}, 32'(status[1]), 0);
    chk("R9 done cleared at start", 32'(status[0]), 0);
    wait_idle(400);
    model_rd = 1'b0;
    chk({req, " data"}, 32'(data_q), 32'(pat));
    chk({req, " done flag"}, 32'(status[0]), 1);
    chk("R2 read bit count", 32'(snap_n), CLEN + 16);
    chk("R2 read command", 32'(snap_frame[24:16]), 32'h195);
  endtask

  task automatic t_period();
    chk("R10 sk period", 32'(sk_period), 32'(2 * CLK_DIV * 5));
  endtask

  task automatic t_erase_nopoll();
    dev_ready = 1'b0;
    cpu_wr(2'd1, 16'h0130);
    cpu_wr(2'd2, 16'h0040);
    chk("R9 done cleared by erase-class start", 32'(status[0]), 0);
    wait_clk(120);
    chk("R5 enable cmd needs no poll", 32'(status[1]), 1);
    chk("R5 enable frame", 32'(snap_frame[8:0]), 32'h130);
    chk("R5 enable bit count", 32'(snap_n), CLEN);
    dev_ready = 1'b1;
  endtask

  task automatic t_erase_poll(input logic [15:0] cmd, input string req);
    dev_ready = 1'b0;
    cpu_wr(2'd1, cmd);
    cpu_wr(2'd2, 16'h0040);
    wait_clk(120);
    chk({req, " still busy"}, 32'(status[1]), 0);
    chk({req, " frame"}, 32'(snap_frame[8:0]), 32'(cmd[8:0]));
    dev_ready = 1'b1;
    wait_idle(50);
    chk({req, " idle after ready"}, 32'(status[1]), 1);
  endtask

  task automatic t_strobe_busy();
    rdpat = 16'h5AA5; model_rd = 1'b1;
    cpu_wr(2'd1, 16'h0195);
    cpu_wr(2'd2, 16'h0010);
    wait_clk(20);
    cpu_wr(2'd1, 16'h016A);
    cpu_wr(2'd2, 16'h0020);
    wait_idle(400);
    model_rd = 1'b0;
    wait_clk(40);
    chk("R11 strobe while busy ignored", 32'(status[1]), 1);
    chk("R11 cs stays low", 32'(ee_cs), 0);
    chk("R11 single read frame", 32'(snap_frame[24:16]), 32'h195);
    chk("R11 read data", 32'(data_q), 32'h5AA5);
  endtask

  task automatic t_protect();
    do_reset();
    cpu_wr(2'd1, 16'h016A);
    cpu_wr(2'd2, 16'h00A0);
    chk("R8 same-write protect blocks strobe", 32'(status[1]), 1);
    chk("R7 protect set", 32'(status[7]), 1);
    wait_clk(40);
    chk("R8 no frame started", 32'(ee_cs), 0);
    cpu_wr(2'd2, 16'h0000);
    chk("R7 zero write keeps protect", 32'(status[7]), 1);
    cpu_wr(2'd1, 16'h01C3);
    cpu_wr(2'd2, 16'h0040);
    chk("R8 erase blocked", 32'(status[1]), 1);
    wait_clk(40);
    chk("R8 erase no cs", 32'(ee_cs), 0);
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset();
    t_write();
    t_read(16'h3C96, 16'h0010, "R4 read");
    t_period();
    t_erase_nopoll();
    t_erase_poll(16'h01C3, "R5 erase word");
    t_erase_poll(16'h0120, "R5 erase all");
    t_read(16'hC0DE, 16'h0030, "R12 read beats write");
    t_strobe_busy();
    t_protect();
    t_read(16'h9182, 16'h0090, "R8 read under protect");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule